// File: doc/BRIEF.md
# Serial Audio-Link Frame Deserializer

This block is the receiving end of a time-slotted serial audio link, placed on the codec side. A frame marker line and a serial data line are sampled once per bit period. A rising edge on the marker line opens a frame. The block then counts 256 bit times and splits them into a 16-bit tag slot followed by twelve 20-bit data slots. The decoded frame appears on a wide parallel output together with a one-cycle strobe.

The block runs on `clk`, which is the link's bit clock inverted. A rising edge of `clk` is therefore the falling edge of the bit clock, and the two lines are sampled on it. The tag slot holds three things: a frame-valid flag, one valid flag for each data slot, and a 2-bit codec address. The block reports all of them, and it reports every slot word whatever its flag says.

A marker rise that arrives anywhere except the frame boundary is flagged as an alignment error. The partial frame is then dropped, and counting restarts from the new rise. A serial link cannot be stalled, so the output carries no ready input. Whatever sits downstream must take each strobed frame in the cycle it appears. The held values stay on the output until the next frame completes.

Top module: `ac_link_rx`

## Requirements
- R1: Exactly one data bit is taken from `sdata_i` on each rising edge of `clk` while a frame is open.
- R2: A frame opens when `sync_i` is seen low on one rising edge of `clk` and high on the next. The bit sampled on the following edge is tag bit 15. The next 255 bits follow in order, down to bit 0 of slot 12.
- R3: `frm_ok_o` equals tag bit 15 of the reported frame.
- R4: `slot_tag_o[k-1]` equals tag bit 15-k, which is the valid flag of data slot k, for k = 1..12.
- R5: `codec_id_o` equals tag bits 1:0.
- R6: Slot words are assembled most significant bit first. Slot k is reported on `slot_data_o[20*(k-1)+19 : 20*(k-1)]`.
- R7: `frm_valid_o` is high for exactly one cycle, namely the cycle right after the edge that samples the last bit of slot 12. Slots whose valid flag is 0 are still reported, with that flag cleared.
- R8: A `sync_i` rise seen on the same edge that samples the last bit of a frame is the correct boundary. It raises no error, and the next frame follows back to back.
- R9: A `sync_i` rise seen at any other point of an open frame drives `align_err_o` high for one cycle, in the cycle after that edge. The partial frame is never reported, and the next sampled bit is taken as tag bit 15 of a new frame.
- R10: No frame is reported after reset until the first `sync_i` rise. A frame that ends with no rise on its last bit leaves the block idle until the next rise.
- R11: While reset is held and just after it, `frm_valid_o`, `align_err_o` and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Inverted bit clock; rising edge is the sampling point |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame marker line |
| sdata_i | input | 1 | Serial data line |
| frm_valid_o | output | 1 | One-cycle strobe: a complete frame is on the outputs |
| frm_ok_o | output | 1 | Frame-valid flag from the tag slot |
| slot_tag_o | output | 12 | Per-slot valid flags, bit k-1 for slot k |
| codec_id_o | output | 2 | Codec address bits from the tag slot |
| slot_data_o | output | 240 | Twelve 20-bit slot words, slot 1 in the lowest bits |
| align_err_o | output | 1 | One-cycle pulse on a misplaced marker rise |

## Verification
Several stimulus patterns are used, and each one separates a different kind of fault.

A long stretch of random data with the marker held low shows whether the block starts framing on its own. Back-to-back frames, each with a distinct tag pattern and random slot words, expose errors in bit order, slot offset and flag mapping. One of these frames has every slot flag cleared, which shows whether invalid slots are wrongly suppressed.

A frame that ends with no following marker rise, followed by a gap, checks that the block goes idle. A marker rise placed in the middle of a frame checks three things: the error pulse and its timing, that the partial frame is discarded, and that the count restarts correctly for the frame after it.

// File: rtl/ac_link_rx_pkg.sv
package ac_link_rx_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } rx_phase_e;
endpackage

// File: rtl/ac_rx_align.sv
module ac_rx_align
  import ac_link_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned PW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic          cap_o,
  output logic          last_o,
  output logic          err_o,
  output logic [PW-1:0] pos_o
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  rx_phase_e     ph;
  logic [PW-1:0] pos;
  logic          sync_q;
  logic          rise;

  assign rise   = sync_i & ~sync_q;
  assign cap_o  = (ph == PH_RUN);
  assign last_o = (ph == PH_RUN) && (pos == LAST);
  assign pos_o  = pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      ph     <= PH_IDLE;
      pos    <= '0;
      err_o  <= 1'b0;
    end else begin
      sync_q <= sync_i;
      err_o  <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (rise) begin
            ph  <= PH_RUN;
            pos <= '0;
          end
        end
        PH_RUN: begin
          if (pos == LAST) begin
            pos <= '0;
            if (!rise) ph <= PH_IDLE;
          end else if (rise) begin
            pos   <= '0;
            err_o <= 1'b1;
          end else begin
            pos <= pos + PW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  assert_err_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (pos == '0) && (ph == PH_RUN));

  assert_pos_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RUN && pos != LAST && !rise) |=> (pos == $past(pos) + PW'(1)));
endmodule

// File: rtl/ac_rx_shift.sv
module ac_rx_shift #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_i,
  input  logic                  sd_i,
  output logic [FRAME_BITS-1:0] frame_o
);
  logic [FRAME_BITS-2:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (cap_i) sr <= {sr[FRAME_BITS-3:0], sd_i};
  end

  // Full frame view in the cycle the final bit is on the line
  assign frame_o = {sr, sd_i};
endmodule

// File: rtl/ac_rx_unpack.sv
module ac_rx_unpack #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned SLOT_W = 20,
  localparam int unsigned FRAME_BITS = TAG_W + SLOTS * SLOT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    last_i,
  input  logic [FRAME_BITS-1:0]   frame_i,
  output logic                    strobe_o,
  output logic                    ok_o,
  output logic [SLOTS-1:0]        flags_o,
  output logic [1:0]              id_o,
  output logic [SLOTS*SLOT_W-1:0] data_o
);
  logic [TAG_W-1:0]        tag;
  logic [SLOTS-1:0]        flags_w;
  logic [SLOTS*SLOT_W-1:0] data_w;
  logic                    unused_rsvd;

  assign tag         = frame_i[FRAME_BITS-1 -: TAG_W];
  assign unused_rsvd = ^tag[TAG_W-2-SLOTS:2];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign flags_w[k] = tag[TAG_W-2-k];
    assign data_w[k*SLOT_W +: SLOT_W] =
      frame_i[FRAME_BITS-TAG_W-1-k*SLOT_W -: SLOT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_o <= 1'b0;
      ok_o     <= 1'b0;
      flags_o  <= '0;
      id_o     <= '0;
      data_o   <= '0;
    end else begin
      strobe_o <= last_i;
      if (last_i) begin
        ok_o    <= tag[TAG_W-1];
        flags_o <= flags_w;
        id_o    <= tag[1:0];
        data_o  <= data_w;
      end
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  assert_strobe_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> $past(last_i));

  assert_ok_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (ok_o == $past(frame_i[FRAME_BITS-1])));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last_i) |-> $stable(data_o));
endmodule

// File: rtl/ac_link_rx.sv
module ac_link_rx #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned SLOT_W = 20,
  localparam int unsigned FRAME_BITS = TAG_W + SLOTS * SLOT_W,
  localparam int unsigned PW = $clog2(FRAME_BITS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_i,
  input  logic                    sdata_i,
  output logic                    frm_valid_o,
  output logic                    frm_ok_o,
  output logic [SLOTS-1:0]        slot_tag_o,
  output logic [1:0]              codec_id_o,
  output logic [SLOTS*SLOT_W-1:0] slot_data_o,
  output logic                    align_err_o
);
  logic                  cap;
  logic                  last;
  logic [PW-1:0]         pos;
  logic [FRAME_BITS-1:0] frame;
  logic                  unused_pos;

  assign unused_pos = ^pos;

  ac_rx_align #(.FRAME_BITS(FRAME_BITS)) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .cap_o  (cap),
    .last_o (last),
    .err_o  (align_err_o),
    .pos_o  (pos)
  );

  ac_rx_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap),
    .sd_i    (sdata_i),
    .frame_o (frame)
  );

  ac_rx_unpack #(.TAG_W(TAG_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_i   (last),
    .frame_i  (frame),
    .strobe_o (frm_valid_o),
    .ok_o     (frm_ok_o),
    .flags_o  (slot_tag_o),
    .id_o     (codec_id_o),
    .data_o   (slot_data_o)
  );

  assert_no_err_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_o |-> !align_err_o);
endmodule

// File: tb/tb_ac_link_rx.sv
module tb_ac_link_rx;
  localparam int FB = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic sdata_i = 1'b0;
  logic frm_valid_o, frm_ok_o, align_err_o;
  logic [11:0]  slot_tag_o;
  logic [1:0]   codec_id_o;
  logic [239:0] slot_data_o;

  always #5 clk = ~clk;

  ac_link_rx dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sdata_i(sdata_i),
    .frm_valid_o(frm_valid_o), .frm_ok_o(frm_ok_o), .slot_tag_o(slot_tag_o),
    .codec_id_o(codec_id_o), .slot_data_o(slot_data_o), .align_err_o(align_err_o)
  );

  typedef struct {
    logic [15:0]  tag;
    logic [239:0] data;
    time          t;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  int   n_strobe = 0;
  int   n_err = 0;
  time  err_t_exp = 0;
  time  err_t_got = 0;
  bit   prev_err = 1'b0;
  bit   prev_stb = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [255:0] build(input logic [15:0] tag, input logic [239:0] d);
    logic [255:0] f;
    f[255:240] = tag;
    for (int k = 0; k < 12; k++) f[239 - 20*k -: 20] = d[20*k +: 20];
    return f;
  endfunction

  // R1: one bit driven per cycle, set at negedge, sampled at the next posedge
  task automatic drive_bit(input logic s, input logic d);
    @(negedge clk);
    sync_i  = s;
    sdata_i = d;
  endtask

  // R2: the bit after the rise is tag bit 15; chained=1 puts the next rise on the last bit (R8)
  task automatic send_frame(input logic [15:0] tag, input logic [239:0] d, input bit chained);
    logic [255:0] f;
    exp_t e;
    f = build(tag, d);
    for (int i = 0; i < FB; i++) begin
      drive_bit((i < 15) || (i == FB-1 && chained), f[FB-1-i]);
    end
    e.tag  = tag;
    e.data = d;
    e.t    = $time + 10;
    exp_q.push_back(e);
  endtask

  function automatic logic [239:0] rnd_data();
    logic [239:0] d;
    for (int k = 0; k < 12; k++) d[20*k +: 20] = 20'($urandom);
    return d;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(!(prev_stb && frm_valid_o), "R7", "strobe width", 256'(frm_valid_o), 256'(0));
      chk(!(prev_err && align_err_o), "R9", "error pulse width", 256'(align_err_o), 256'(0));
      prev_stb = frm_valid_o;
      prev_err = align_err_o;
      if (align_err_o) begin
        n_err++;
        err_t_got = $time;
      end
      if (frm_valid_o) begin
        n_strobe++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected frame", 256'(1), 256'(0));
        end else begin
          exp_t e;
          logic [11:0] ef;
          e = exp_q.pop_front();
          for (int k = 0; k < 12; k++) ef[k] = e.tag[14-k];
          chk($time == e.t, "R7", "strobe time", 256'($time), 256'(e.t));
          chk(frm_ok_o == e.tag[15], "R3", "frame ok", 256'(frm_ok_o), 256'(e.tag[15]));
          chk(slot_tag_o == ef, "R4", "slot flags", 256'(slot_tag_o), 256'(ef));
          chk(codec_id_o == e.tag[1:0], "R5", "codec id", 256'(codec_id_o), 256'(e.tag[1:0]));
          chk(slot_data_o == e.data, "R6", "slot words", 256'(slot_data_o), 256'(e.data));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [255:0] pf;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({frm_valid_o, align_err_o, frm_ok_o, slot_tag_o, codec_id_o} == '0 && slot_data_o == '0,
        "R11", "reset outputs", 256'({frm_valid_o, align_err_o, slot_data_o}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_valid_o == 1'b0 && align_err_o == 1'b0, "R11", "outputs after reset",
        256'({frm_valid_o, align_err_o}), 256'(0));

    // R10: random data with the marker low produces nothing
    for (int i = 0; i < 300; i++) drive_bit(1'b0, 1'($urandom));
    drive_bit(1'b0, 1'b0);
    chk(n_strobe == 0, "R10", "frames before first rise", 256'(n_strobe), 256'(0));

    // R2: first rise, then back-to-back frames (R8)
    drive_bit(1'b1, 1'b0);
    send_frame(16'hA5F3, rnd_data(), 1'b1);
    send_frame(16'h0002, rnd_data(), 1'b1);   // R7: all slot flags clear, still reported
    send_frame(16'hFFF9, rnd_data(), 1'b0);
    for (int i = 0; i < 40; i++) drive_bit(1'b0, 1'($urandom));
    chk(n_strobe == 3, "R10", "idle after unchained frame", 256'(n_strobe), 256'(3));
    chk(n_err == 0, "R8", "no error at proper boundary", 256'(n_err), 256'(0));

    // R9: misplaced rise mid-frame
    drive_bit(1'b1, 1'b0);
    pf = build(16'h8001, rnd_data());
    for (int i = 0; i < 100; i++) drive_bit(i < 15, pf[FB-1-i]);
    drive_bit(1'b1, 1'b1);
    err_t_exp = $time + 10;
    send_frame(16'hC3C1, rnd_data(), 1'b0);
    for (int i = 0; i < 10; i++) drive_bit(1'b0, 1'b0);

    chk(n_err == 1, "R9", "error count", 256'(n_err), 256'(1));
    chk(err_t_got == err_t_exp, "R9", "error time", 256'(err_t_got), 256'(err_t_exp));
    chk(n_strobe == 4, "R9", "partial frame dropped", 256'(n_strobe), 256'(4));
    chk(exp_q.size() == 0, "R7", "all frames reported", 256'(exp_q.size()), 256'(0));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule